// File: doc/BRIEF.md
# Prescaled Reloadable Interval Timer

This block is a low-frequency interval timer. A slow reference clock enters as an asynchronous signal. It is synchronised and edge-detected in the system clock domain. A power-of-two prescaler then divides the reference edges into timer ticks. Each tick decrements a down-counter. When the counter passes zero it reloads from a programmable register and raises a one-cycle event pulse. Other logic can use the rising edge of that pulse as a wake or interrupt source. The prescaled tick is brought out as well, so that a downstream watchdog prescaler can count either raw reference edges or timer ticks.

Software programs the block through a simple write port and reads it through a registered read port. There are four registers: configuration, prescale code, reload value, and control/status.

A restart command loads the counter from the reload register and starts it. The load takes effect only on a reference edge. The command bit reads back as 1 until the slow-domain acknowledgement has come back through a synchroniser.

Lock bits in the configuration register freeze registers against further writes. Once set, a lock bit is cleared only by reset.

Top module: `ival_timer`

## Requirements
- R1: After reset the block reads as follows, and `event_o` is low:
  - configuration (address 0) reads 0;
  - prescale code (address 1) reads 0;
  - reload (address 2) reads all ones;
  - control/status (address 3) reads 0, meaning not busy and not running.
- R2: Prescale code c, held in bits [3:0] of address 1, makes `tick_o` pulse once every 2^c reference rising edges. Code 0 means one tick per reference edge.
- R3: While running, `event_o` pulses once every (reload+1) ticks. The counter reloads itself automatically, so the events are periodic.
- R4: `event_o` is high for exactly one clock cycle per expiry. Its rising edge marks the timeout.
- R5: Writing 1 to bit 0 of address 3 starts a restart request. That bit reads 1 until the restart has been applied on a reference edge and the acknowledgement has been synchronised back. With no reference edges it stays 1.
- R6: The restart loads the reload value held at the reference edge where it is applied, and sets the running flag (bit 1 of address 3). A restart write while bit 0 is still 1 is ignored and does not cancel the pending request.
- R7: `wdog_clk_en_o` carries the raw reference-edge pulse when configuration bit 3 is 0. It carries the prescaled tick when that bit is 1.
- R8: Each lock bit makes writes to one register ignored:
  - configuration bit 0 locks the configuration register;
  - bit 1 locks the prescale register;
  - bit 2 locks the reload register.
- R9: Writes to the configuration register can set lock bits but never clear them. Only reset clears a lock bit.
- R10: Read data appears on `rd_data_o` one clock after `rd_addr_i` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Asynchronous slow reference clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | CNT_W | Registered read data |
| event_o | output | 1 | One-cycle expiry pulse |
| tick_o | output | 1 | Prescaled tick pulse |
| wdog_clk_en_o | output | 1 | Selected count enable for a watchdog prescaler |

## Verification
The hardest state to reach from the ports is a restart that is still pending while the slow domain has not yet acted on it. In normal running, a reference edge arrives within a few cycles and the busy bit clears almost at once. The bench therefore stops the reference clock entirely, then issues a restart, a new reload value and a second restart. It then checks that the busy bit stays set and that the second write has not cancelled the first. After the reference clock resumes, the event spacing must match the reload value written during the stall. The other cases check event and tick spacing in system cycles, which is exactly 10·2^c·(reload+1) for a 10-cycle reference period.

// File: rtl/ival_pkg.sv
package ival_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG    = 2'd0,
    ADDR_PRESC  = 2'd1,
    ADDR_RELOAD = 2'd2,
    ADDR_CTRL   = 2'd3
  } ival_addr_e;

  localparam int CFG_W        = 4;
  localparam int CFG_LOCK_CFG = 0;
  localparam int CFG_LOCK_PS  = 1;
  localparam int CFG_LOCK_RL  = 2;
  localparam int CFG_WD_SEL   = 3;
  localparam int CTRL_RESTART = 0;
  localparam int CTRL_RUNNING = 1;
endpackage

// File: rtl/ival_ref_sync.sv
module ival_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_i,
  output logic ref_pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      prev_q      <= 1'b0;
      ref_pulse_o <= 1'b0;
    end else begin
      sync_q      <= {sync_q[STAGES-2:0], ref_clk_i};
      prev_q      <= sync_q[STAGES-1];
      ref_pulse_o <= sync_q[STAGES-1] & ~prev_q;
    end
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
    ref_pulse_o |=> !ref_pulse_o);
endmodule

// File: rtl/ival_prescaler.sv
module ival_prescaler #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_pulse_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int PS_W = (1 << CODE_W) - 1;

  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign mask[i] = (32'(code_i) > i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (ref_pulse_i) begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= ((cnt_q & mask) == mask);
    end else begin
      tick_o <= 1'b0;
    end
  end

  assert_tick_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(ref_pulse_i));
endmodule

// File: rtl/ival_restart_hs.sv
module ival_restart_hs #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse_i,
  input  logic start_i,
  output logic apply_o,
  output logic busy_o
);
  logic              req_t_q;
  logic              done_t_q;
  logic [STAGES-1:0] ack_sync_q;

  assign busy_o  = req_t_q ^ ack_sync_q[STAGES-1];
  assign apply_o = ref_pulse_i & (req_t_q ^ done_t_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_t_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      req_t_q <= ~req_t_q;
    end
  end

  // slow side: acts only on reference edges
  always_ff @(posedge clk) begin
    if (rst) begin
      done_t_q <= 1'b0;
    end else if (apply_o) begin
      done_t_q <= req_t_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[STAGES-2:0], done_t_q};
    end
  end

  assert_busy_clear_acked_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (ack_sync_q[STAGES-1] != $past(ack_sync_q[STAGES-1])));
  assert_apply_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    apply_o |-> busy_o);
endmodule

// File: rtl/ival_counter.sv
module ival_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             event_o,
  output logic             running_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      running_o <= 1'b0;
      event_o   <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= reload_i;
      running_o <= 1'b1;
      event_o   <= 1'b0;
    end else if (running_o && tick_i) begin
      if (cnt_q == '0) begin
        cnt_q   <= reload_i;
        event_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_q - 1'b1;
        event_o <= 1'b0;
      end
    end else begin
      event_o <= 1'b0;
    end
  end

  assert_event_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o);
  assert_event_from_tick_R3: assert property (@(posedge clk) disable iff (rst)
    event_o |-> ($past(tick_i) && running_o));
endmodule

// File: rtl/ival_regs.sv
module ival_regs
  import ival_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [1:0]        rd_addr_i,
  input  logic              busy_i,
  input  logic              running_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              wd_sel_o,
  output logic              restart_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             lock_cfg, lock_ps, lock_rl;
  logic             wr_cfg, wr_ps, wr_rl;

  assign lock_cfg = cfg_q[CFG_LOCK_CFG];
  assign lock_ps  = cfg_q[CFG_LOCK_PS];
  assign lock_rl  = cfg_q[CFG_LOCK_RL];
  assign wd_sel_o = cfg_q[CFG_WD_SEL];

  assign wr_cfg    = wr_en_i && (wr_addr_i == ADDR_CFG)    && !lock_cfg;
  assign wr_ps     = wr_en_i && (wr_addr_i == ADDR_PRESC)  && !lock_ps;
  assign wr_rl     = wr_en_i && (wr_addr_i == ADDR_RELOAD) && !lock_rl;
  assign restart_o = wr_en_i && (wr_addr_i == ADDR_CTRL)   && wr_data_i[CTRL_RESTART];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      code_o   <= '0;
      reload_o <= '1;
    end else begin
      if (wr_cfg) begin
        cfg_q[CFG_WD_SEL] <= wr_data_i[CFG_WD_SEL];
        cfg_q[CFG_LOCK_RL:CFG_LOCK_CFG] <= cfg_q[CFG_LOCK_RL:CFG_LOCK_CFG]
                                         | wr_data_i[CFG_LOCK_RL:CFG_LOCK_CFG];
      end
      if (wr_ps) code_o <= wr_data_i[CODE_W-1:0];
      if (wr_rl) reload_o <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      unique case (ival_addr_e'(rd_addr_i))
        ADDR_CFG:    rd_data_o <= CNT_W'(cfg_q);
        ADDR_PRESC:  rd_data_o <= CNT_W'(code_o);
        ADDR_RELOAD: rd_data_o <= reload_o;
        ADDR_CTRL:   rd_data_o <= CNT_W'({running_i, busy_i});
        default:     rd_data_o <= '0;
      endcase
    end
  end

  assert_locks_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_q[CFG_LOCK_RL:CFG_LOCK_CFG]) & ~cfg_q[CFG_LOCK_RL:CFG_LOCK_CFG]) == '0);
  assert_reload_locked_R8: assert property (@(posedge clk) disable iff (rst)
    lock_rl |=> $stable(reload_o));
  assert_presc_locked_R8: assert property (@(posedge clk) disable iff (rst)
    lock_ps |=> $stable(code_o));
  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (rst)
    lock_cfg |=> $stable(cfg_q));
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             event_o,
  output logic             tick_o,
  output logic             wdog_clk_en_o
);
  logic              ref_pulse, apply, busy, running, wd_sel, restart;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  reload;

  ival_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk_i), .ref_pulse_o(ref_pulse));

  ival_regs #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .busy_i(busy),
    .running_i(running), .rd_data_o(rd_data_o), .code_o(code),
    .reload_o(reload), .wd_sel_o(wd_sel), .restart_o(restart));

  ival_restart_hs #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst(rst), .ref_pulse_i(ref_pulse), .start_i(restart),
    .apply_o(apply), .busy_o(busy));

  ival_prescaler #(.CODE_W(CODE_W)) u_ps (
    .clk(clk), .rst(rst), .ref_pulse_i(ref_pulse), .clear_i(apply),
    .code_i(code), .tick_o(tick_o));

  ival_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(apply), .tick_i(tick_o),
    .reload_i(reload), .event_o(event_o), .running_o(running));

  always_ff @(posedge clk) begin
    if (rst) wdog_clk_en_o <= 1'b0;
    else     wdog_clk_en_o <= wd_sel ? tick_o : ref_pulse;
  end

  assert_wd_source_R7: assert property (@(posedge clk) disable iff (rst)
    wdog_clk_en_o |-> ($past(tick_o) || $past(ref_pulse)));
endmodule

// File: tb/sim_ival_timer.sv
module sim_ival_timer;
  localparam int W = 16;
  localparam int REF_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ref_clk = 1'b0;
  logic         ref_run = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         event_o, tick_o, wd_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_q[$];
  bit skip = 1'b1;
  int last_ev = 0;
  bit ev_prev = 1'b0;

  ival_timer u0 (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .event_o(event_o), .tick_o(tick_o),
    .wdog_clk_en_o(wd_en));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (REF_P / 2) @(negedge clk);
    if (ref_run) ref_clk = ~ref_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // scoreboard monitor: compares event spacing against queued expectations
  always @(negedge clk) begin
    if (!rst) begin
      if (event_o) begin
        chk(!ev_prev, "R4 event width", 2, 1);
        if (skip || exp_q.size() == 0) begin
          skip = 1'b0;
        end else begin
          int e;
          e = exp_q.pop_front();
          chk((cyc - last_ev) == e, "R3 event period", cyc - last_ev, e);
        end
        last_ev = cyc;
      end
      ev_prev = event_o;
    end
  end

  task automatic wait_idle(output logic [W-1:0] v);
    v = '1;
    for (int i = 0; i < 200 && v[0]; i++) rd(2'd3, v);
  endtask

  task automatic run_case(input int code, input int rl, input int n);
    logic [W-1:0] v;
    while (exp_q.size() != 0) @(negedge clk);
    wr(2'd1, W'(code));
    wr(2'd2, W'(rl));
    wr(2'd3, 16'h1);
    rd(2'd3, v);
    chk(v[0] == 1'b1, "R5 busy after restart", v[0], 1);
    wait_idle(v);
    chk(v[1:0] == 2'b10, "R6 running, busy cleared", v[1:0], 2);
    skip = 1'b1;
    for (int i = 0; i < n; i++) exp_q.push_back(REF_P * (1 << code) * (rl + 1));
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic spacing(input bit use_wd, input int exp, input string req);
    int t0;
    if (use_wd) begin
      do @(negedge clk); while (!wd_en);
      t0 = cyc;
      do @(negedge clk); while (!wd_en);
    end else begin
      do @(negedge clk); while (!tick_o);
      t0 = cyc;
      do @(negedge clk); while (!tick_o);
    end
    chk((cyc - t0) == exp, req, cyc - t0, exp);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R10 read latency
    rd(2'd0, v); chk(v == 16'h0, "R1 cfg reset", v, 0);
    rd(2'd1, v); chk(v == 16'h0, "R1 presc reset", v, 0);
    rd(2'd2, v); chk(v == 16'hFFFF, "R1 R10 reload reset", v, 16'hFFFF);
    rd(2'd3, v); chk(v == 16'h0, "R1 ctrl reset", v, 0);
    chk(event_o == 1'b0, "R1 event low", event_o, 0);

    // R7 raw reference pulse on watchdog enable
    spacing(1'b1, REF_P, "R7 wd raw source");

    // R3 and R2 periods over several patterns
    run_case(0, 0, 3);
    run_case(0, 3, 3);
    run_case(2, 4, 3);
    run_case(3, 2, 3);
    run_case(5, 1, 2);

    // R2 tick spacing and R7 prescaled source
    wr(2'd1, 16'd3);
    spacing(1'b0, REF_P * 8, "R2 tick spacing code3");
    wr(2'd0, 16'h8);
    spacing(1'b1, REF_P * 8, "R7 wd prescaled source");
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd0);
    spacing(1'b0, REF_P, "R2 tick spacing code0");

    // R5/R6 restart pending with the reference clock halted
    while (exp_q.size() != 0) @(negedge clk);
    ref_run = 1'b0;
    repeat (20) @(negedge clk);
    wr(2'd3, 16'h1);
    wr(2'd2, 16'd5);
    wr(2'd3, 16'h1);
    repeat (60) @(negedge clk);
    rd(2'd3, v);
    chk(v[0] == 1'b1, "R5 R6 busy held without ref edge", v[0], 1);
    ref_run = 1'b1;
    wait_idle(v);
    chk(v[0] == 1'b0, "R5 busy clears after ack", v[0], 0);
    skip = 1'b1;
    for (int i = 0; i < 2; i++) exp_q.push_back(REF_P * 6);
    while (exp_q.size() != 0) @(negedge clk);

    // R8/R9 locks
    wr(2'd0, 16'hC);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk(v == 16'd5, "R8 reload locked", v, 5);
    wr(2'd0, 16'h0);
    rd(2'd0, v); chk(v == 16'h4, "R9 lock sticky", v, 4);
    wr(2'd0, 16'h2);
    wr(2'd1, 16'd7);
    rd(2'd1, v); chk(v == 16'd0, "R8 presc locked", v, 0);
    wr(2'd0, 16'h1);
    wr(2'd0, 16'h8);
    rd(2'd0, v); chk(v == 16'h7, "R8 cfg locked", v, 7);

    // R9 reset clears locks
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    rd(2'd0, v); chk(v == 16'h0, "R9 locks cleared by reset", v, 0);
    wr(2'd2, 16'h00AB);
    rd(2'd2, v); chk(v == 16'h00AB, "R9 reload writable after reset", v, 16'hAB);

    finish_run();
  end
endmodule